// File: doc/BRIEF.md
# Mode-Selectable Four-State Sequence Generator

This block is a four-state Mealy machine that walks one of two state orders, picked by a single mode input. With the mode high it bounces between the first two states. With the mode low it runs a permuted four-state loop. Each transition drives a 2-bit output code, and no register sits between the logic and that output.

The machine moves only on clock edges where a step strobe is high. A slow tick from a clock divider can therefore pace it while the whole block stays on the fast clock. While the strobe is low, the output shows the number of the state the machine is in. While the strobe is high, the output shows the number of the state the coming edge will enter. An active-high reset forces the home state at once, without waiting for a clock edge.

Top module: `seqgen_top`

## Requirements
- R1: Raising `rst` forces the state to state 0 at once, with no clock edge needed. While `rst` is high and `step_en` is low, `dout` reads 0.
- R2: With `mode` = 1 and `step_en` = 1 on every edge, the machine moves from state 0 to state 1 and from state 1 back to state 0.
- R3: With `mode` = 0 and `step_en` = 1 on every edge, the machine repeats the order 0, 2, 1, 3, 0.
- R4: While `step_en` = 1, `dout` holds the binary number of the state the next rising edge enters. For example it reads 2 in state 0 with `mode` = 0, and 3 in state 1 with `mode` = 0.
- R5: From state 3, a step always goes to state 0, whatever `mode` is, and `dout` reads 0 during that step.
- R6: On an edge where `step_en` = 0 the state holds. During such a cycle `dout` shows the current state number (state codes: 0 = 2'b00, 1 = 2'b01, 2 = 2'b10, 3 = 2'b11).
- R7: A step taken after `mode` has changed follows the new mode: state 2 with `mode` = 1 goes to state 0 and outputs 0; state 1 with `mode` = 0 goes to state 3 and outputs 3.
- R8: `dout` is combinational. A change on `mode` or `step_en` shows up on `dout` within the same cycle, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset to state 0 |
| step_en | input | 1 | Advance strobe, sampled on the rising edge |
| mode | input | 1 | 1 = two-state toggle, 0 = four-state loop |
| dout | output | 2 | Mealy output code |

## Verification
A wrong state register is visible at the ports within one cycle: with `step_en` low, `dout` exposes the held state directly. With `step_en` high, `dout` shows where the next edge will lead, so a bad next-state entry appears as a wrong code before the edge that would commit it. A bad stored state also corrupts every code after it until reset, so every step is compared with a model, and mode flips are made in every state.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int STATE_W = 2;
  typedef enum logic [STATE_W-1:0] {
    ST_ZERO  = 2'd0,
    ST_ONE   = 2'd1,
    ST_TWO   = 2'd2,
    ST_THREE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seqgen_next.sv
module seqgen_next
  import seqgen_pkg::*;
(
  input  seq_state_e cur_state,
  input  logic       mode,
  output seq_state_e nxt_state
);
  always_comb begin
    case (cur_state)
      ST_ZERO:  nxt_state = mode ? ST_ONE  : ST_TWO;
      ST_ONE:   nxt_state = mode ? ST_ZERO : ST_THREE;
      ST_TWO:   nxt_state = mode ? ST_ZERO : ST_ONE;
      ST_THREE: nxt_state = ST_ZERO;
      default:  nxt_state = ST_ZERO;
    endcase
  end
endmodule

// File: rtl/seqgen_state_reg.sv
module seqgen_state_reg
  import seqgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  seq_state_e nxt_state,
  output seq_state_e state_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)          state_q <= ST_ZERO;
    else if (step_en) state_q <= nxt_state;
  end
endmodule

// File: rtl/seqgen_out_decode.sv
module seqgen_out_decode
  import seqgen_pkg::*;
(
  input  seq_state_e           cur_state,
  input  seq_state_e           nxt_state,
  input  logic                 step_en,
  output logic [STATE_W-1:0]   code
);
  always_comb code = step_en ? STATE_W'(nxt_state) : STATE_W'(cur_state);
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic               mode,
  output logic [STATE_W-1:0] dout
);
  seq_state_e state_q;
  seq_state_e nxt_state;

  seqgen_next u_next (
    .cur_state(state_q),
    .mode     (mode),
    .nxt_state(nxt_state)
  );

  seqgen_state_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .nxt_state(nxt_state),
    .state_q  (state_q)
  );

  seqgen_out_decode u_dec (
    .cur_state(state_q),
    .nxt_state(nxt_state),
    .step_en  (step_en),
    .code     (dout)
  );
endmodule

// File: rtl/seqgen_checker.sv
module seqgen_checker
  import seqgen_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               step_en,
  input logic               mode,
  input logic [STATE_W-1:0] dout,
  input logic [STATE_W-1:0] state_q
);
  assert_reset_home_R1: assert property (@(posedge clk)
    rst |-> state_q == 2'd0);

  assert_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && mode && state_q == 2'd0) |=> state_q == 2'd1);

  assert_loop_R3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !mode && state_q == 2'd0) |=> state_q == 2'd2);

  assert_enter_code_R4: assert property (@(posedge clk) disable iff (rst)
    step_en |=> state_q == $past(dout));

  assert_three_home_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_q == 2'd3) |=> state_q == 2'd0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(state_q));

  assert_mode_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (step_en && !mode && state_q == 2'd1) |=> state_q == 2'd3);
endmodule

bind seqgen_top seqgen_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .step_en(step_en),
  .mode   (mode),
  .dout   (dout),
  .state_q(state_q)
);

// File: tb/seqgen_top_tb.sv
module seqgen_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] dout;
  logic [1:0] model = 2'd0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  seqgen_top u_dut (.clk(clk), .rst(rst), .step_en(step_en), .mode(mode), .dout(dout));

  always #10 clk = ~clk;

  function automatic logic [1:0] nxt(input logic [1:0] s, input logic m);
    case (s)
      2'd0: nxt = m ? 2'd1 : 2'd2;
      2'd1: nxt = m ? 2'd0 : 2'd3;
      2'd2: nxt = m ? 2'd0 : 2'd1;
      default: nxt = 2'd0;
    endcase
  endfunction

  task automatic check(input logic [1:0] exp, input string tag);
    n_cmp++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%0d expected=%0d", tag, dout, exp);
    end
  endtask

  task automatic step(input logic m, input logic s, input string tag);
    @(negedge clk);
    mode = m; step_en = s;
    #2;
    check(s ? nxt(model, m) : model, tag);
    @(posedge clk);
    if (s) model = nxt(model, m);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #3 rst = 1'b1; step_en = 1'b0;
    #2 check(2'd0, "R1 async reset");
    @(negedge clk);
    rst = 1'b0;
    model = 2'd0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #2 check(2'd0, "R1 reset state");
    @(negedge clk) rst = 1'b0;
    step(1'b1, 1'b0, "R6 hold after reset");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R2 toggle");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R3 loop R4 code");
    // reach state 3 then step with mode high (R5)
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R3 walk");
    step(1'b1, 1'b0, "R6 hold in state 3");
    step(1'b1, 1'b1, "R5 three to zero mode high");
    // mode flip in every state (R7)
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 2; v++) begin
        do_reset();
        for (int i = 0; i < k; i++) step(1'b0, 1'b1, "R7 walk");
        step(v[0], 1'b1, "R7 flip");
        step(v[0], 1'b0, "R7 landed");
      end
    end
    // combinational output within a cycle (R8)
    do_reset();
    @(negedge clk);
    mode = 1'b0; step_en = 1'b0;
    #2 check(2'd0, "R8 idle");
    step_en = 1'b1;
    #2 check(2'd2, "R8 step mode0");
    mode = 1'b1;
    #2 check(2'd1, "R8 step mode1");
    step_en = 1'b0;
    // reset in the middle of the loop (R1)
    step(1'b0, 1'b1, "R3 pre-reset");
    step(1'b0, 1'b1, "R3 pre-reset");
    do_reset();
    step(1'b0, 1'b0, "R1 home after mid reset");
    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 39) == 0) do_reset();
      else step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "R4 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule